// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block chooses the next fetch address of an instruction pipeline in the same cycle as the fetch. The current fetch PC drives the instruction cache and, in parallel, a direct-mapped table of known branches. The table index is an XOR fold of two PC fields, and a stored tag made of the upper PC bits confirms the match. When the entry is present and its two-bit saturating counter leans taken, the stored target becomes the next PC. The taken branch then flows into decode with no bubble behind it. In every other case the next PC is the sequential address.

A resolve port, driven by later pipeline stages, reports each fetched branch once its real direction and target are known, together with the prediction that was made for it. The block updates a hitting entry, or allocates an entry for a taken branch that missed. When the prediction was wrong it drives a redirect to the correct address and marks the instruction fetched in that cycle invalid. Squashed fetches travel on as bubbles and never write a destination. The redirect always wins over the table's own prediction.

Top module: `fetch_target_buffer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fetch_pc_o` equals the `RESET_VEC` parameter, and every table entry is invalid. Until a resolve allocates an entry, no fetch address reports a hit.
- R2: When there is neither a redirect nor a taken prediction, the fetch PC of the next cycle is the current fetch PC plus 4.
- R3: When the current fetch PC hits a taken-leaning entry and there is no redirect, `pred_taken_o` is 1 and `pred_target_o` is the stored target in that same cycle, and the next fetch PC is that target.
- R4: The table index is `pc[7:2] ^ pc[13:8]` and the tag is `pc[31:8]`. `pred_hit_o` is 1 only for a valid entry whose tag equals the fetch PC tag. An address that shares the index but differs in the tag is a miss.
- R5: A resolved taken branch that misses in the table allocates its entry with the resolved target and counter value 2, so its next lookup predicts taken.
- R6: A resolved not-taken branch that misses in the table leaves the table unchanged.
- R7: On a resolve hit, the counter rises by one for taken, saturating at 3, and falls by one for not taken, saturating at 0. An entry predicts taken exactly when its counter is 2 or 3.
- R8: On a resolve hit, the stored target is replaced with `rs_target_i`.
- R9: A resolve is mispredicted when its real direction differs from `rs_pred_taken_i`, or when it is taken and `rs_target_i` differs from `rs_pred_target_i`. A mispredict raises `redirect_o`, and the next fetch PC is `rs_target_i` if taken, else `rs_pc_i` plus 4.
- R10: `fetch_valid_o` is 0 in exactly the cycles in which `redirect_o` is 1, which squashes the wrong-path fetch.
- R11: When a redirect and a taken prediction fall in the same cycle, the next fetch PC is the redirect address.
- R12: A correctly predicted resolve, or a cycle with no resolve, does not raise `redirect_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rs_valid_i | input | 1 | A branch outcome is being reported this cycle |
| rs_pc_i | input | ADDR_W | Address of the resolved branch |
| rs_taken_i | input | 1 | Real direction of the branch |
| rs_target_i | input | ADDR_W | Real taken target of the branch |
| rs_pred_taken_i | input | 1 | Direction that was predicted at fetch |
| rs_pred_target_i | input | ADDR_W | Target that was predicted at fetch |
| fetch_pc_o | output | ADDR_W | Current fetch address, shared with the instruction cache |
| fetch_valid_o | output | 1 | The instruction fetched this cycle is on the correct path |
| pred_hit_o | output | 1 | The fetch address matched a table entry |
| pred_taken_o | output | 1 | The matched entry predicts taken |
| pred_target_o | output | ADDR_W | Stored target of the matched entry |
| redirect_o | output | 1 | A mispredict is being corrected this cycle |
| redirect_pc_o | output | ADDR_W | Correct address that fetch restarts at |

## Verification
The two functions that can meet in one cycle are a mispredict redirect from the resolve port and a taken prediction made by the table for the current fetch. The bench first steers fetch onto a branch that it has trained to lean taken. In that same cycle it reports an unrelated mispredicted branch. The outcome is judged by the fetch PC of the following cycle, which must be the redirect address, and by `fetch_valid_o` being low in the colliding cycle. A resolve that rewrites the very entry being read in the same cycle is also provoked; there the fetch must still see the old contents.

// File: rtl/fb_pkg.sv
package fb_pkg;

    // Source of the next fetch address, in falling priority order.
    typedef enum logic [1:0] {
        NPC_REDIR = 2'd0,
        NPC_PRED  = 2'd1,
        NPC_SEQ   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/fb_hash.sv
module fb_hash #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    // Fold the low index field with the field just above it.
    assign idx = pc[OFF_W +: IDX_W] ^ pc[OFF_W+IDX_W +: IDX_W];
    // The tag keeps every bit above the first field, so the pair is exact.
    assign tag = pc[ADDR_W-1 : OFF_W+IDX_W];
endmodule

// File: rtl/fb_table.sv
module fb_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    parameter int CTR_W  = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    // fetch read port
    input  logic [IDX_W-1:0]  fa_idx,
    output logic              fa_valid,
    output logic [TAG_W-1:0]  fa_tag,
    output logic [ADDR_W-1:0] fa_target,
    output logic [CTR_W-1:0]  fa_ctr,
    // resolve read port
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [CTR_W-1:0]  rb_ctr,
    // single write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic [CTR_W-1:0]  wr_ctr
);
    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];
    logic [CTR_W-1:0]  ctr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Payload needs no reset: it is never used while its valid bit is clear.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
            ctr_q[wr_idx] <= wr_ctr;
        end
    end

    assign fa_valid  = vld_q[fa_idx];
    assign fa_tag    = tag_q[fa_idx];
    assign fa_target = tgt_q[fa_idx];
    assign fa_ctr    = ctr_q[fa_idx];

    assign rb_valid  = vld_q[rb_idx];
    assign rb_tag    = tag_q[rb_idx];
    assign rb_ctr    = ctr_q[rb_idx];
endmodule

// File: rtl/fb_update.sv
module fb_update #(
    parameter int CTR_W = 2
) (
    input  logic             rs_valid,
    input  logic             rs_taken,
    input  logic             rs_hit,
    input  logic [CTR_W-1:0] ctr_old,
    output logic             wr_en,
    output logic [CTR_W-1:0] ctr_new
);
    localparam logic [CTR_W-1:0] CTR_MAX   = '1;
    localparam logic [CTR_W-1:0] CTR_MIN   = '0;
    localparam logic [CTR_W-1:0] CTR_ALLOC = CTR_W'(1) << (CTR_W - 1);

    // A not-taken miss is dropped; anything else writes the entry.
    assign wr_en = rs_valid && (rs_hit || rs_taken);

    always_comb begin
        if (!rs_hit) begin
            ctr_new = CTR_ALLOC;
        end else if (rs_taken) begin
            ctr_new = (ctr_old == CTR_MAX) ? CTR_MAX : ctr_old + CTR_W'(1);
        end else begin
            ctr_new = (ctr_old == CTR_MIN) ? CTR_MIN : ctr_old - CTR_W'(1);
        end
    end
endmodule

// File: rtl/fb_next_pc.sv
module fb_next_pc
    import fb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    input  logic              pred_taken,
    input  logic [ADDR_W-1:0] pred_target,
    output npc_src_e          src,
    output logic [ADDR_W-1:0] next_pc
);
    always_comb begin
        if (redirect) begin
            src = NPC_REDIR;
        end else if (pred_taken) begin
            src = NPC_PRED;
        end else begin
            src = NPC_SEQ;
        end
    end

    always_comb begin
        unique case (src)
            NPC_REDIR: next_pc = redirect_pc;
            NPC_PRED:  next_pc = pred_target;
            NPC_SEQ:   next_pc = cur_pc + ADDR_W'(STEP);
            default:   next_pc = cur_pc + ADDR_W'(STEP);
        endcase
    end
endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
    import fb_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          IDX_W       = 6,
    parameter int          CTR_W       = 2,
    parameter int          INSTR_BYTES = 4,
    parameter logic [31:0] RESET_VEC   = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rs_valid_i,
    input  logic [ADDR_W-1:0] rs_pc_i,
    input  logic              rs_taken_i,
    input  logic [ADDR_W-1:0] rs_target_i,
    input  logic              rs_pred_taken_i,
    input  logic [ADDR_W-1:0] rs_pred_target_i,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic              fetch_valid_o,
    output logic              pred_hit_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] pred_target_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_pc_o
);
    localparam int OFF_W = $clog2(INSTR_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [ADDR_W-1:0] pc_q, pc_d;
    npc_src_e          npc_src;

    logic [IDX_W-1:0]  f_idx, r_idx;
    logic [TAG_W-1:0]  f_tag, r_tag;
    logic              fa_valid, rb_valid;
    logic [TAG_W-1:0]  fa_tag, rb_tag;
    logic [ADDR_W-1:0] fa_target;
    logic [CTR_W-1:0]  fa_ctr, rb_ctr, wr_ctr;
    logic              r_hit, wr_en, mispredict;

    fb_hash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_hash_fetch (
        .pc(pc_q), .idx(f_idx), .tag(f_tag)
    );

    fb_hash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_hash_resolve (
        .pc(rs_pc_i), .idx(r_idx), .tag(r_tag)
    );

    fb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .fa_idx    (f_idx),
        .fa_valid  (fa_valid),
        .fa_tag    (fa_tag),
        .fa_target (fa_target),
        .fa_ctr    (fa_ctr),
        .rb_idx    (r_idx),
        .rb_valid  (rb_valid),
        .rb_tag    (rb_tag),
        .rb_ctr    (rb_ctr),
        .wr_en     (wr_en),
        .wr_idx    (r_idx),
        .wr_tag    (r_tag),
        .wr_target (rs_target_i),
        .wr_ctr    (wr_ctr)
    );

    // Fetch-side lookup: valid entry, exact tag, counter upper half.
    assign pred_hit_o    = fa_valid && (fa_tag == f_tag);
    assign pred_taken_o  = pred_hit_o && fa_ctr[CTR_W-1];
    assign pred_target_o = fa_target;

    // Resolve-side verification of the earlier prediction.
    assign r_hit      = rb_valid && (rb_tag == r_tag);
    assign mispredict = rs_valid_i &&
                        ((rs_taken_i != rs_pred_taken_i) ||
                         (rs_taken_i && (rs_target_i != rs_pred_target_i)));

    fb_update #(.CTR_W(CTR_W)) u_update (
        .rs_valid (rs_valid_i),
        .rs_taken (rs_taken_i),
        .rs_hit   (r_hit),
        .ctr_old  (rb_ctr),
        .wr_en    (wr_en),
        .ctr_new  (wr_ctr)
    );

    assign redirect_o    = mispredict;
    assign redirect_pc_o = rs_taken_i ? rs_target_i : rs_pc_i + ADDR_W'(INSTR_BYTES);
    assign fetch_valid_o = !mispredict;

    fb_next_pc #(.ADDR_W(ADDR_W), .STEP(INSTR_BYTES)) u_next (
        .cur_pc      (pc_q),
        .redirect    (redirect_o),
        .redirect_pc (redirect_pc_o),
        .pred_taken  (pred_taken_o),
        .pred_target (pred_target_o),
        .src         (npc_src),
        .next_pc     (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= ADDR_W'(RESET_VEC);
        end else begin
            pc_q <= pc_d;
        end
    end

    assign fetch_pc_o = pc_q;
endmodule

// File: rtl/fetch_target_buffer_chk.sv
module fetch_target_buffer_chk #(
    parameter int          ADDR_W      = 32,
    parameter int          INSTR_BYTES = 4,
    parameter logic [31:0] RESET_VEC   = 32'h0000_1000
) (
    input logic              clk,
    input logic              rst,
    input logic              rs_valid_i,
    input logic              rs_taken_i,
    input logic              rs_pred_taken_i,
    input logic [ADDR_W-1:0] fetch_pc_o,
    input logic              fetch_valid_o,
    input logic              pred_hit_o,
    input logic              pred_taken_o,
    input logic [ADDR_W-1:0] pred_target_o,
    input logic              redirect_o,
    input logic [ADDR_W-1:0] redirect_pc_o
);
    a_r1_reset_vector: assert property (@(posedge clk)
        $past(rst) |-> fetch_pc_o == ADDR_W'(RESET_VEC));

    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        (!pred_taken_o && !redirect_o) |=> fetch_pc_o == $past(fetch_pc_o) + ADDR_W'(INSTR_BYTES));

    a_r3_zero_bubble: assert property (@(posedge clk) disable iff (rst)
        (pred_taken_o && !redirect_o) |=> fetch_pc_o == $past(pred_target_o));

    a_r7_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        pred_taken_o |-> pred_hit_o);

    a_r9_redirect_target: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> fetch_pc_o == $past(redirect_pc_o));

    a_r10_squash: assert property (@(posedge clk) disable iff (rst)
        (rs_valid_i && (rs_taken_i != rs_pred_taken_i)) |-> (redirect_o && !fetch_valid_o));

    a_r11_redirect_wins: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && pred_taken_o) |=> fetch_pc_o == $past(redirect_pc_o));

    a_r12_quiet_without_resolve: assert property (@(posedge clk) disable iff (rst)
        !rs_valid_i |-> (!redirect_o && fetch_valid_o));
endmodule

bind fetch_target_buffer fetch_target_buffer_chk #(
    .ADDR_W      (ADDR_W),
    .INSTR_BYTES (INSTR_BYTES),
    .RESET_VEC   (RESET_VEC)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .rs_valid_i      (rs_valid_i),
    .rs_taken_i      (rs_taken_i),
    .rs_pred_taken_i (rs_pred_taken_i),
    .fetch_pc_o      (fetch_pc_o),
    .fetch_valid_o   (fetch_valid_o),
    .pred_hit_o      (pred_hit_o),
    .pred_taken_o    (pred_taken_o),
    .pred_target_o   (pred_target_o),
    .redirect_o      (redirect_o),
    .redirect_pc_o   (redirect_pc_o)
);

// File: tb/fetch_target_buffer_test.sv
module fetch_target_buffer_test;
    localparam logic [31:0] RV   = 32'h0000_1000;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        rs_valid_i = 1'b0, rs_taken_i = 1'b0, rs_pred_taken_i = 1'b0;
    logic [31:0] rs_pc_i = '0, rs_target_i = '0, rs_pred_target_i = '0;
    logic [31:0] fetch_pc_o, pred_target_o, redirect_pc_o;
    logic        fetch_valid_o, pred_hit_o, pred_taken_o, redirect_o;

    fetch_target_buffer #(.RESET_VEC(RV)) uut (
        .clk(clk), .rst(rst),
        .rs_valid_i(rs_valid_i), .rs_pc_i(rs_pc_i), .rs_taken_i(rs_taken_i),
        .rs_target_i(rs_target_i), .rs_pred_taken_i(rs_pred_taken_i),
        .rs_pred_target_i(rs_pred_target_i),
        .fetch_pc_o(fetch_pc_o), .fetch_valid_o(fetch_valid_o),
        .pred_hit_o(pred_hit_o), .pred_taken_o(pred_taken_o),
        .pred_target_o(pred_target_o), .redirect_o(redirect_o),
        .redirect_pc_o(redirect_pc_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference table built from the requirements.
    logic        mv  [64];
    logic [23:0] mt  [64];
    logic [31:0] mtg [64];
    logic [1:0]  mc  [64];
    logic [31:0] m_pc;
    string       pc_tag;

    function automatic logic [5:0] hix(logic [31:0] p);
        return p[7:2] ^ p[13:8];
    endfunction

    function automatic logic [23:0] htg(logic [31:0] p);
        return p[31:8];
    endfunction

    function automatic logic [31:0] chain_tgt(int i);
        return BASE + 32'(((5 * i + 1) % 64) * 4);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive a resolve, check every output against the model, advance.
    task automatic cyc(input logic v, input logic [31:0] rpc, input logic tk,
                       input logic [31:0] tgt, input logic ptk, input logic [31:0] ptgt);
        int fi, ri;
        logic e_hit, e_pt, mis, r_hit;
        logic [31:0] e_tgt, r_pc;
        rs_valid_i = v; rs_pc_i = rpc; rs_taken_i = tk; rs_target_i = tgt;
        rs_pred_taken_i = ptk; rs_pred_target_i = ptgt;
        #1;
        fi    = int'(hix(m_pc));
        e_hit = mv[fi] && (mt[fi] == htg(m_pc));
        e_pt  = e_hit && (mc[fi] >= 2'd2);
        e_tgt = mtg[fi];
        mis   = v && ((tk != ptk) || (tk && (tgt != ptgt)));
        r_pc  = tk ? tgt : rpc + 32'd4;
        chk(fetch_pc_o == m_pc, pc_tag, fetch_pc_o, m_pc);
        chk(pred_hit_o == e_hit, "R4 hit", 32'(pred_hit_o), 32'(e_hit));
        if (e_hit) chk(pred_taken_o == e_pt, "R7 direction", 32'(pred_taken_o), 32'(e_pt));
        if (e_pt)  chk(pred_target_o == e_tgt, "R3 target", pred_target_o, e_tgt);
        chk(redirect_o == mis, mis ? "R9 redirect" : "R12 no redirect", 32'(redirect_o), 32'(mis));
        chk(fetch_valid_o == !mis, "R10 squash", 32'(fetch_valid_o), 32'(!mis));
        if (mis) begin
            m_pc   = r_pc;
            pc_tag = e_pt ? "R11 priority" : "R9 next pc";
        end else if (e_pt) begin
            m_pc   = e_tgt;
            pc_tag = "R3 next pc";
        end else begin
            m_pc   = m_pc + 32'd4;
            pc_tag = "R2 next pc";
        end
        if (v) begin
            ri    = int'(hix(rpc));
            r_hit = mv[ri] && (mt[ri] == htg(rpc));
            if (r_hit) begin
                if (tk) mc[ri] = (mc[ri] == 2'd3) ? 2'd3 : mc[ri] + 2'd1;
                else    mc[ri] = (mc[ri] == 2'd0) ? 2'd0 : mc[ri] - 2'd1;
                mtg[ri] = tgt;
            end else if (tk) begin
                mv[ri] = 1'b1; mt[ri] = htg(rpc); mtg[ri] = tgt; mc[ri] = 2'd2;
            end
        end
        @(posedge clk);
        #1;
        rs_valid_i = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
    endtask

    // Redirect fetch to x through a not-taken branch at x-4 that was predicted taken.
    task automatic steer(input logic [31:0] x);
        cyc(1'b1, x - 32'd4, 1'b0, '0, 1'b1, '0);
    endtask

    // Resolve a branch reporting exactly what the model predicts, so no redirect.
    task automatic resolve_agree(input logic [31:0] p, input logic tk);
        int k;
        k = int'(hix(p));
        cyc(1'b1, p, tk, mtg[k], mv[k] && (mt[k] == htg(p)) && (mc[k] >= 2'd2), mtg[k]);
    endtask

    initial begin
        logic [31:0] alias_pc, x;
        for (int i = 0; i < 64; i++) begin
            mv[i] = 1'b0; mt[i] = '0; mtg[i] = '0; mc[i] = '0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(fetch_pc_o == RV, "R1 reset pc", fetch_pc_o, RV);
        chk(fetch_valid_o == 1'b1, "R1 reset valid", 32'(fetch_valid_o), 32'd1);
        chk(redirect_o == 1'b0, "R1 reset redirect", 32'(redirect_o), 32'd0);
        rst = 1'b0;
        m_pc = RV; pc_tag = "R1 first pc";

        // Sweep every index with an empty table: all misses, sequential fetch.
        for (int i = 0; i < 64; i++) idle();

        // Allocate one taken branch per index; targets form a single cycle.
        for (int i = 0; i < 64; i++)
            cyc(1'b1, BASE + 32'(i * 4), 1'b1, chain_tgt(i), 1'b0, '0);

        // Walk the chain: every fetch hits and jumps with no bubble.
        steer(BASE);
        for (int i = 0; i < 64; i++) begin
            chk(pred_taken_o == 1'b1, "R5 allocated predicts taken", 32'(pred_taken_o), 32'd1);
            idle();
        end

        // Same index, different tag.
        alias_pc = (BASE + 32'd20) ^ 32'h0000_0104;
        steer(alias_pc);
        chk(pred_hit_o == 1'b0, "R4 alias miss", 32'(pred_hit_o), 32'd0);
        idle();

        // Not-taken miss must not allocate.
        x = 32'h0003_0000;
        resolve_agree(x, 1'b0);
        steer(x);
        chk(pred_hit_o == 1'b0, "R6 no allocation", 32'(pred_hit_o), 32'd0);
        idle();

        // Counter saturation.
        x = BASE + 32'd8;
        repeat (3) resolve_agree(x, 1'b1);
        resolve_agree(x, 1'b0);
        steer(x);
        chk(pred_taken_o == 1'b1, "R7 saturated high", 32'(pred_taken_o), 32'd1);
        idle();
        repeat (4) resolve_agree(x, 1'b0);
        steer(x);
        chk(pred_hit_o == 1'b1 && pred_taken_o == 1'b0, "R7 saturated low",
            32'(pred_taken_o), 32'd0);
        idle();
        resolve_agree(x, 1'b1);
        steer(x);
        chk(pred_taken_o == 1'b0, "R7 one step up", 32'(pred_taken_o), 32'd0);
        idle();
        resolve_agree(x, 1'b1);
        steer(x);
        chk(pred_taken_o == 1'b1, "R7 two steps up", 32'(pred_taken_o), 32'd1);
        idle();

        // Target overwrite with a target mispredict.
        x = BASE + 32'd12;
        cyc(1'b1, x, 1'b1, 32'h0004_0000, 1'b1, mtg[int'(hix(x))]);
        chk(fetch_pc_o == 32'h0004_0000, "R9 target mismatch", fetch_pc_o, 32'h0004_0000);
        steer(x);
        chk(pred_target_o == 32'h0004_0000, "R8 target rewritten", pred_target_o, 32'h0004_0000);
        idle();

        // Redirect and taken prediction in the same cycle.
        steer(BASE + 32'd16);
        chk(pred_taken_o == 1'b1, "R11 setup", 32'(pred_taken_o), 32'd1);
        cyc(1'b1, 32'h0006_0000, 1'b1, 32'h0005_0000, 1'b0, '0);
        chk(fetch_pc_o == 32'h0005_0000, "R11 redirect wins", fetch_pc_o, 32'h0005_0000);

        // Resolve rewriting the entry the fetch reads in the same cycle.
        x = BASE + 32'd24;
        steer(x);
        cyc(1'b1, x, 1'b1, 32'h0007_0000, 1'b1, 32'h0007_0004);
        steer(x);
        idle();

        for (int i = 0; i < 8; i++) idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule